// File: doc/BRIEF.md
# PRBS Test Configuration Sequencer

This block switches one serial lane into pseudo-random bit sequence test mode, and later switches it back, by driving the lane's configuration register port. A single start command launches a fixed series of seven accesses: three that set up the transmit pattern generator, then four that set up the receive pattern checker. Each access is a read-modify-write. The sequencer reads the register, waits for the data, merges new values into the bits it owns, and writes the result back. Every bit outside those fields keeps the value it had.

Once the lane writes are done, the sequencer pulses a soft-reset bit through a separate management write port. It sets the bit with one write and clears it with a second write on a later cycle. A done pulse then marks the end of the run. Several choices are sampled at start: the polynomial, the inversion of each direction, and the checker's lead-in threshold. These are folded into the write values. A restore option uses the same series of accesses to return every owned field to zero.

Top module: `lane_prbs_cfg_seq`

## Requirements
- R1: After reset `busy`, `done`, `reg_rd`, `reg_wr` and `mgmt_wr` are all low.
- R2: A run accesses lane offsets 0x006, 0x007, 0x008, 0x00A, 0x00B, 0x00C, 0x13F in that order, with exactly one read followed by one write at each offset.
- R3: Each write equals the read data with only the owned bits replaced: 0x006 mask 0xCF, 0x007 mask 0xE4, 0x008 mask 0x10, 0x00A mask 0x90, 0x00B mask 0xEE, 0x00C mask 0x0B, 0x13F mask 0x0F. No other offset is written.
- R4: In test mode the fixed fields are 0x006 = 0x44 within its mask, 0x00A bit 7 = 1, 0x00B bit 1 = 1, 0x00C bit 1 = 1 and bit 3 = 0, and 0x13F bits [3:0] = 4'b1110.
- R5: `poly_sel` values 0, 1, 2 and 3 select the 9, 15, 23 and 31 polynomials. Values 0 to 2 set bit 5, 6 or 7 of both 0x007 and 0x00B. Value 3 sets 0x008 bit 4 and 0x00C bit 0. All other polynomial bits are 0.
- R6: In test mode, 0x007 bit 2 equals `tx_noinv`, 0x00A bit 4 equals `rx_noinv`, and 0x00B bits [3:2] equal `chk_thresh`.
- R7: A read request is held until a cycle with `reg_wait` low. The write for an offset is issued only after `reg_rvalid` has returned that offset's data. A write is held with stable data until a cycle with `reg_wait` low.
- R8: After the last lane write, the block makes two management writes to address 0x13. The first has data 0x4 (bit 2 set). The second is accepted on a later cycle with data 0. There are no lane accesses in between.
- R9: With `restore` high at start, every owned field is written to 0 and the other bits keep their values. The access order and the reset pulse are the same as in test mode.
- R10: `start` is accepted only while idle. A start during a run has no effect. All settings are sampled in the start cycle.
- R11: `busy` is high from the cycle after an accepted start until the clearing management write is accepted. `done` is then high for exactly one cycle, with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a run (accepted only when idle) |
| restore | input | 1 | 1: write defaults back, 0: enter test mode |
| poly_sel | input | 2 | Polynomial choice: 0=9, 1=15, 2=23, 3=31 |
| tx_noinv | input | 1 | 1: transmitted pattern not inverted |
| rx_noinv | input | 1 | 1: received pattern expected not inverted |
| chk_thresh | input | 2 | Checker lead-in threshold code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| reg_addr | output | 10 | Lane register offset |
| reg_rd | output | 1 | Lane read request |
| reg_wr | output | 1 | Lane write request |
| reg_wdata | output | 8 | Lane write data |
| reg_rdata | input | 8 | Lane read data |
| reg_wait | input | 1 | Lane port stall; request held while high |
| reg_rvalid | input | 1 | Lane read data valid |
| mgmt_addr | output | 8 | Management write address |
| mgmt_wr | output | 1 | Management write request |
| mgmt_wdata | output | 32 | Management write data |
| mgmt_wait | input | 1 | Management port stall |

## Verification
The bench preloads the lane registers with all-ones, all-zeros and mixed patterns. A design that wrote whole bytes, or used the wrong mask, would then show changed neighbour bits. A lane and management model inserts pseudo-random wait states, which catches a design that drops a stalled request or writes before the read data returns. The bench also issues a second start with different settings in the middle of a run. A sequencer that restarts, or that samples its settings late, produces extra accesses or wrong polynomial bits. The bench then checks that both reset writes follow the last lane write on separate cycles and that `done` lasts one cycle.

// File: rtl/prbs_cfg_pkg.sv
package prbs_cfg_pkg;

    localparam int LANE_AW   = 10;
    localparam int LANE_DW   = 8;
    localparam int NUM_STEPS = 7;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [1:0] {
        POLY_9  = 2'd0,
        POLY_15 = 2'd1,
        POLY_23 = 2'd2,
        POLY_31 = 2'd3
    } poly_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RWAIT,
        ST_WR,
        ST_RSTON,
        ST_RSTOFF
    } state_e;

    // Settings captured when a run starts
    typedef struct packed {
        logic       restore;
        poly_e      poly;
        logic       tx_noinv;
        logic       rx_noinv;
        logic [1:0] thresh;
    } cfg_t;

    // One masked access
    typedef struct packed {
        logic [LANE_AW-1:0] addr;
        logic [LANE_DW-1:0] mask;
        logic [LANE_DW-1:0] value;
    } step_t;

    // One-hot select for the three short polynomials, bit 0 = 9
    function automatic logic [2:0] short_poly_onehot(poly_e p);
        return {p == POLY_23, p == POLY_15, p == POLY_9};
    endfunction

    function automatic step_t step_lookup(logic [STEP_W-1:0] idx, cfg_t c);
        step_t      s;
        logic [2:0] ph;
        logic       p31;
        ph  = short_poly_onehot(c.poly);
        p31 = (c.poly == POLY_31);
        s   = '0;
        case (idx)
            3'd0: s = '{addr: 10'h006, mask: 8'hCF, value: 8'h44};
            3'd1: s = '{addr: 10'h007, mask: 8'hE4,
                        value: {ph, 2'b00, c.tx_noinv, 2'b00}};
            3'd2: s = '{addr: 10'h008, mask: 8'h10,
                        value: {3'b000, p31, 4'b0000}};
            3'd3: s = '{addr: 10'h00A, mask: 8'h90,
                        value: {1'b1, 2'b00, c.rx_noinv, 4'b0000}};
            3'd4: s = '{addr: 10'h00B, mask: 8'hEE,
                        value: {ph, 1'b0, c.thresh, 1'b1, 1'b0}};
            3'd5: s = '{addr: 10'h00C, mask: 8'h0B,
                        value: {4'b0000, 2'b00, 1'b1, p31}};
            3'd6: s = '{addr: 10'h13F, mask: 8'h0F, value: 8'h0E};
            default: s = '0;
        endcase
        if (c.restore) begin
            s.value = '0;
        end
        return s;
    endfunction

    function automatic logic [LANE_DW-1:0] masked_merge(
        logic [LANE_DW-1:0] old_v,
        logic [LANE_DW-1:0] mask,
        logic [LANE_DW-1:0] new_v
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/prbs_step_table.sv
module prbs_step_table
    import prbs_cfg_pkg::*;
(
    input  logic [STEP_W-1:0] step_idx,
    input  cfg_t              cfg,
    output step_t             step
);

    always_comb begin
        step = step_lookup(step_idx, cfg);
    end

endmodule

// File: rtl/prbs_rmw_unit.sv
module prbs_rmw_unit
    import prbs_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [LANE_DW-1:0] old_data,
    input  logic [LANE_DW-1:0] mask,
    input  logic [LANE_DW-1:0] value,
    output logic [LANE_DW-1:0] merged
);

    logic [LANE_DW-1:0] merged_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            merged_q <= '0;
        end else if (capture) begin
            merged_q <= masked_merge(old_data, mask, value);
        end
    end

    assign merged = merged_q;

endmodule

// File: rtl/lane_prbs_cfg_seq.sv
module lane_prbs_cfg_seq
    import prbs_cfg_pkg::*;
#(
    parameter int                 MGMT_AW       = 8,
    parameter int                 MGMT_DW       = 32,
    parameter logic [MGMT_AW-1:0] MGMT_RST_ADDR = 8'h13,
    parameter int                 RST_BIT       = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               restore,
    input  logic [1:0]         poly_sel,
    input  logic               tx_noinv,
    input  logic               rx_noinv,
    input  logic [1:0]         chk_thresh,
    output logic               busy,
    output logic               done,
    output logic [LANE_AW-1:0] reg_addr,
    output logic               reg_rd,
    output logic               reg_wr,
    output logic [LANE_DW-1:0] reg_wdata,
    input  logic [LANE_DW-1:0] reg_rdata,
    input  logic               reg_wait,
    input  logic               reg_rvalid,
    output logic [MGMT_AW-1:0] mgmt_addr,
    output logic               mgmt_wr,
    output logic [MGMT_DW-1:0] mgmt_wdata,
    input  logic               mgmt_wait
);

    localparam logic [STEP_W-1:0]  LAST_STEP = STEP_W'(NUM_STEPS - 1);
    localparam logic [MGMT_DW-1:0] RST_WORD  = MGMT_DW'(1) << RST_BIT;

    state_e            state_q;
    cfg_t              cfg_q;
    logic [STEP_W-1:0] step_q;
    step_t             cur_step;
    logic              done_q;
    logic              rd_fire;
    logic              wr_fire;
    logic              mgmt_fire;
    logic              capture;

    assign rd_fire   = reg_rd && !reg_wait;
    assign wr_fire   = reg_wr && !reg_wait;
    assign mgmt_fire = mgmt_wr && !mgmt_wait;
    assign capture   = (state_q == ST_RWAIT) && reg_rvalid;

    prbs_step_table u_table (
        .step_idx (step_q),
        .cfg      (cfg_q),
        .step     (cur_step)
    );

    prbs_rmw_unit u_rmw (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .old_data (reg_rdata),
        .mask     (cur_step.mask),
        .value    (cur_step.value),
        .merged   (reg_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            cfg_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q.restore  <= restore;
                        cfg_q.poly     <= poly_e'(poly_sel);
                        cfg_q.tx_noinv <= tx_noinv;
                        cfg_q.rx_noinv <= rx_noinv;
                        cfg_q.thresh   <= chk_thresh;
                        step_q         <= '0;
                        state_q        <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (rd_fire) state_q <= ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (reg_rvalid) state_q <= ST_WR;
                end
                ST_WR: begin
                    if (wr_fire) begin
                        if (step_q == LAST_STEP) begin
                            state_q <= ST_RSTON;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= ST_RD;
                        end
                    end
                end
                ST_RSTON: begin
                    if (mgmt_fire) state_q <= ST_RSTOFF;
                end
                ST_RSTOFF: begin
                    if (mgmt_fire) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign reg_addr   = cur_step.addr;
    assign reg_rd     = (state_q == ST_RD);
    assign reg_wr     = (state_q == ST_WR);
    assign mgmt_addr  = MGMT_RST_ADDR;
    assign mgmt_wr    = (state_q == ST_RSTON) || (state_q == ST_RSTOFF);
    assign mgmt_wdata = (state_q == ST_RSTON) ? RST_WORD : '0;

endmodule

// File: rtl/prbs_cfg_seq_chk.sv
module prbs_cfg_seq_chk #(
    parameter int MGMT_DW = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic               reg_wait,
    input logic               reg_rvalid,
    input logic [9:0]         reg_addr,
    input logic [7:0]         reg_wdata,
    input logic               mgmt_wr,
    input logic               mgmt_wait,
    input logic [MGMT_DW-1:0] mgmt_wdata
);

    logic have_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_data <= 1'b0;
        end else if (reg_wr && !reg_wait) begin
            have_data <= 1'b0;
        end else if (reg_rvalid && busy) begin
            have_data <= 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !busy && !done && !reg_rd && !reg_wr && !mgmt_wr); // R1

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr)); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_wait |=> reg_rd && $stable(reg_addr)); // R7

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_wait |=> reg_wr && $stable(reg_wdata) && $stable(reg_addr)); // R7

    AST_WR_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> have_data); // R7

    AST_MGMT_ALONE: assert property (@(posedge clk) disable iff (rst)
        mgmt_wr |-> !reg_rd && !reg_wr); // R8

    AST_RST_SET_THEN_CLR: assert property (@(posedge clk) disable iff (rst)
        mgmt_wr && !mgmt_wait && mgmt_wdata[2] |=> mgmt_wr && !mgmt_wdata[2]); // R8

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11

endmodule

bind lane_prbs_cfg_seq prbs_cfg_seq_chk #(.MGMT_DW(MGMT_DW)) u_chk (.*);

// File: tb/test_lane_prbs_cfg_seq.sv
`timescale 1ns/1ps
module test_lane_prbs_cfg_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        restore = 1'b0;
    logic [1:0]  poly_sel = 2'd0;
    logic        tx_noinv = 1'b0;
    logic        rx_noinv = 1'b0;
    logic [1:0]  chk_thresh = 2'd0;
    logic        busy, done;
    logic [9:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata = 8'h00;
    logic        reg_wait = 1'b0;
    logic        reg_rvalid = 1'b0;
    logic [7:0]  mgmt_addr;
    logic        mgmt_wr;
    logic [31:0] mgmt_wdata;
    logic        mgmt_wait = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lane_prbs_cfg_seq i_lane_prbs_cfg_seq (
        .clk(clk), .rst(rst), .start(start), .restore(restore),
        .poly_sel(poly_sel), .tx_noinv(tx_noinv), .rx_noinv(rx_noinv),
        .chk_thresh(chk_thresh), .busy(busy), .done(done),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
        .reg_rvalid(reg_rvalid), .mgmt_addr(mgmt_addr), .mgmt_wr(mgmt_wr),
        .mgmt_wdata(mgmt_wdata), .mgmt_wait(mgmt_wait)
    );

    // ---------------- lane and management port model ----------------
    logic [7:0]  mem [0:511];
    logic [7:0]  lfsr = 8'h5B;
    logic        stall_en = 1'b0;
    logic        p1v = 1'b0;
    logic [9:0]  p1a = '0;
    int          cyc = 0;
    int          rd_n, wr_n, mg_n, done_n, order_err, mg_addr_bad;
    logic [9:0]  rd_log [0:31];
    logic [9:0]  wr_log [0:31];
    logic [31:0] mg_log [0:7];
    int          mg_cyc [0:7];
    int          last_lane_cyc;
    logic [9:0]  last_rd;
    logic        have_rd;

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        reg_wait <= stall_en & lfsr[0];
        mgmt_wait <= stall_en & lfsr[2];
        p1v        <= reg_rd && !reg_wait;
        p1a        <= reg_addr;
        reg_rvalid <= p1v;
        reg_rdata  <= mem[p1a[8:0]];
        if (reg_rvalid) have_rd <= 1'b1;
        if (reg_rd && !reg_wait) begin
            if (rd_n < 32) rd_log[rd_n] <= reg_addr;
            rd_n    <= rd_n + 1;
            last_rd <= reg_addr;
        end
        if (reg_wr && !reg_wait) begin
            mem[reg_addr[8:0]] <= reg_wdata;
            if (wr_n < 32) wr_log[wr_n] <= reg_addr;
            wr_n <= wr_n + 1;
            if (!have_rd || last_rd != reg_addr) order_err <= order_err + 1;
            have_rd       <= 1'b0;
            last_lane_cyc <= cyc;
        end
        if (mgmt_wr && !mgmt_wait) begin
            if (mg_n < 8) begin
                mg_log[mg_n] <= mgmt_wdata;
                mg_cyc[mg_n] <= cyc;
            end
            mg_n <= mg_n + 1;
            if (mgmt_addr != 8'h13) mg_addr_bad <= mg_addr_bad + 1;
        end
        if (done) done_n <= done_n + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Owned mask and field value per offset, written bit by bit
    function automatic logic [15:0] owned(input logic [9:0] a, input bit rest,
                                          input logic [1:0] pol, input bit ti,
                                          input bit ri, input logic [1:0] th);
        logic [7:0] m, v;
        m = 8'h00; v = 8'h00;
        case (a)
            10'h006: begin m = 8'b1100_1111; v[2] = 1'b1; v[6] = 1'b1; end
            10'h007: begin
                m[2] = 1; m[5] = 1; m[6] = 1; m[7] = 1;
                v[2] = ti; v[5] = (pol == 0); v[6] = (pol == 1); v[7] = (pol == 2);
            end
            10'h008: begin m[4] = 1; v[4] = (pol == 3); end
            10'h00A: begin m[4] = 1; m[7] = 1; v[4] = ri; v[7] = 1'b1; end
            10'h00B: begin
                m[1] = 1; m[2] = 1; m[3] = 1; m[5] = 1; m[6] = 1; m[7] = 1;
                v[1] = 1'b1; v[3:2] = th;
                v[5] = (pol == 0); v[6] = (pol == 1); v[7] = (pol == 2);
            end
            10'h00C: begin m[0] = 1; m[1] = 1; m[3] = 1; v[0] = (pol == 3); v[1] = 1'b1; end
            10'h13F: begin m = 8'h0F; v = 8'h0E; end
            default: begin m = 8'h00; v = 8'h00; end
        endcase
        if (rest) v = 8'h00;
        return {m, v};
    endfunction

    logic [9:0] seq_addr [0:6] = '{10'h006, 10'h007, 10'h008, 10'h00A,
                                   10'h00B, 10'h00C, 10'h13F};

    task automatic run_case(input string name, input bit rest, input logic [1:0] pol,
                            input bit ti, input bit ri, input logic [1:0] th,
                            input logic [7:0] pre, input bit stall, input bit interfere);
        string tag;
        logic [15:0] mv;
        logic [7:0] expv;
        bit got_done;
        tag = rest ? "R9" : "R3/R4/R5/R6";
        @(negedge clk);
        for (int i = 0; i < 7; i++) mem[seq_addr[i][8:0]] = pre;
        mem[9'h009] = pre;
        mem[9'h13E] = pre;
        rd_n = 0; wr_n = 0; mg_n = 0; done_n = 0; order_err = 0;
        mg_addr_bad = 0; have_rd = 1'b0; last_lane_cyc = 0;
        stall_en = stall;
        restore = rest; poly_sel = pol; tx_noinv = ti; rx_noinv = ri; chk_thresh = th;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R11", {name, " busy after start"}, 32'(busy), 1);
        // R10: inputs changed after the start cycle must not matter
        poly_sel = pol + 2'd1; tx_noinv = ~ti; rx_noinv = ~ri; chk_thresh = ~th;
        restore = ~rest;
        if (interfere) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got_done = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin
                got_done = 1'b1;
                break;
            end
        end
        check(got_done, "R11", {name, " done seen"}, 32'(got_done), 1);
        check(busy === 1'b0, "R11", {name, " busy low with done"}, 32'(busy), 0);
        @(negedge clk);
        check(done === 1'b0, "R11", {name, " done one cycle"}, 32'(done), 0);
        check(done_n == 1, "R11", {name, " done count"}, done_n, 1);
        check(rd_n == 7, "R2/R10", {name, " read count"}, rd_n, 7);
        check(wr_n == 7, "R2/R10", {name, " write count"}, wr_n, 7);
        for (int i = 0; i < 7; i++) begin
            check(wr_log[i] == seq_addr[i], "R2", {name, " write order"},
                  32'(wr_log[i]), 32'(seq_addr[i]));
            check(rd_log[i] == seq_addr[i], "R2", {name, " read order"},
                  32'(rd_log[i]), 32'(seq_addr[i]));
            mv   = owned(seq_addr[i], rest, pol, ti, ri, th);
            expv = (pre & ~mv[15:8]) | (mv[7:0] & mv[15:8]);
            check(mem[seq_addr[i][8:0]] == expv, tag, {name, " register value"},
                  32'(mem[seq_addr[i][8:0]]), 32'(expv));
        end
        check(mem[9'h009] == pre && mem[9'h13E] == pre, "R3", {name, " neighbours kept"},
              32'({mem[9'h009], mem[9'h13E]}), 32'({pre, pre}));
        check(order_err == 0, "R7", {name, " write after read data"}, order_err, 0);
        check(mg_n == 2, "R8", {name, " mgmt write count"}, mg_n, 2);
        check(mg_log[0] == 32'h4, "R8", {name, " reset set word"}, mg_log[0], 32'h4);
        check(mg_log[1] == 32'h0, "R8", {name, " reset clear word"}, mg_log[1], 32'h0);
        check(mg_cyc[1] > mg_cyc[0], "R8", {name, " clear on later cycle"}, mg_cyc[1], mg_cyc[0] + 1);
        check(mg_cyc[0] > last_lane_cyc, "R8", {name, " reset after lane writes"},
              mg_cyc[0], last_lane_cyc + 1);
        check(mg_addr_bad == 0, "R8", {name, " mgmt address 0x13"}, mg_addr_bad, 0);
        stall_en = 1'b0;
    endtask

    task automatic test_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R1", "busy/done after reset", 32'({busy, done}), 0);
        check(!reg_rd && !reg_wr && !mgmt_wr, "R1", "requests after reset",
              32'({reg_rd, reg_wr, mgmt_wr}), 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        test_reset();
        run_case("poly9",   1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 8'hFF, 1'b0, 1'b0);
        run_case("poly31",  1'b0, 2'd3, 1'b1, 1'b1, 2'd3, 8'h00, 1'b1, 1'b1);
        run_case("poly15",  1'b0, 2'd1, 1'b0, 1'b1, 2'd2, 8'hA5, 1'b1, 1'b0);
        run_case("poly23",  1'b0, 2'd2, 1'b1, 1'b0, 2'd1, 8'h5A, 1'b0, 1'b1);
        run_case("restore", 1'b1, 2'd2, 1'b1, 1'b1, 2'd3, 8'hFF, 1'b1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule